// File: doc/BRIEF.md
# Three-Phase Inverter Gating Generator

This block turns one reference clock into three square-wave gate signals for the switches of a three-phase bridge. A six-state counter runs once per output period, so the reference clock has to run at six times the wanted output frequency. The counter is a three-stage twisted ring. Each phase output is one of its stage bits, passed through an exclusive-OR with a fixed polarity. All three phases come from one shared counter state, so they stay exactly one third of a period apart and cannot drift relative to each other.

The phase outputs and a cycle marker are registered, so the exclusive-OR decode cannot put glitches on them. A synchronous active-high reset starts the output period at state 0. Holding the enable low stops the counter and the outputs. The ring also leaves its two unused codes on the next advance, so a corrupted state cannot lock it up.

Top module: `tri_gate_gen`

## Requirements
- R1: While `rst` is high at a clock edge, the outputs after that edge are `phase_o` = 3'b101 (bit 0 = phase U high, bit 1 = phase V low, bit 2 = phase W high) and `cyc_mark` = 0. This is the pattern of state 0.
- R2: Each clock edge with `en` high and `rst` low moves the generator one state forward, from 0 to 5 and then back to 0. Phase U (bit 0) is high in states 0, 1 and 2. Phase V (bit 1) is high in states 2, 3 and 4. Phase W (bit 2) is high in states 4, 5 and 0. The first edge after reset shows state 1.
- R3: While enabled, each phase repeats every six clocks and is high for exactly three clocks of each six.
- R4: Phase V rises two enabled clocks after phase U rises, and phase W rises two enabled clocks after phase V rises.
- R5: An edge with `en` low and `rst` low leaves `phase_o` unchanged. When `en` returns high, the sequence continues from the state it stopped in.
- R6: `cyc_mark` is high for exactly the one clock after an enabled edge that moves the generator into state 0. It is low at every other time, including after edges with `en` low.
- R7: Every enabled advance changes exactly one bit of `phase_o`, and that change happens only at a clock edge.
- R8: A reset applied in the middle of a period returns the outputs to state 0 at that edge, whatever the level of `en`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference clock, six times the output frequency |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Advance enable; low freezes the sequence |
| phase_o | output | 3 | Registered gate signals: bit 0 = U, bit 1 = V, bit 2 = W |
| cyc_mark | output | 1 | One-clock pulse when the outputs enter state 0 |

## Verification
The phase bits and the marker both come from one register stage, loaded with the decode of the counter's next value. Each result therefore appears right after the same edge that samples `rst` or `en`. The bench changes inputs on the falling edge and reads the outputs one nanosecond after the next rising edge. At that point it compares them against a state index it keeps itself, and it moves that index only when it has driven an enabled edge. The period, duty and two-clock offset checks count edges in that same sampling slot, so a one-cycle slip in the design shows up as a wrong count.

// File: rtl/tgg_pkg.sv
package tgg_pkg;
  localparam int RING_W   = 3;
  localparam int NUM_PH   = 3;
  localparam int SEL_W    = $clog2(RING_W);
  localparam int NSTATE   = 2 * RING_W;

  // start code of the ring: stage 0 set, others clear
  localparam logic [RING_W-1:0] RING_S0 = {{(RING_W-1){1'b0}}, 1'b1};

  // phase k takes stage PH_SEL[k] of the ring, xored with PH_INV[k]
  localparam logic [NUM_PH*SEL_W-1:0] PH_SEL = {2'd1, 2'd2, 2'd0};
  localparam logic [NUM_PH-1:0]       PH_INV = 3'b100;
endpackage

// File: rtl/tgg_ring.sv
module tgg_ring
  import tgg_pkg::*;
#(
  parameter int W = RING_W
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         en,
  output logic [W-1:0] seq_d,
  output logic [W-1:0] seq_q
);
  localparam logic [W-1:0] START = {{(W-1){1'b0}}, 1'b1};

  logic [W-1:0] shifted;
  logic [W-1:0] edges;
  logic         legal;

  assign shifted[0] = ~seq_q[W-1];
  assign edges[0]   = 1'b0;

  genvar i;
  generate
    for (i = 1; i < W; i++) begin : g_stage
      assign shifted[i] = seq_q[i-1];
      assign edges[i]   = seq_q[i] ^ seq_q[i-1];
    end
  endgenerate

  // a valid twisted-ring code has at most one internal boundary
  assign legal = ($countones(edges) <= 1);

  always_comb begin
    if (rst)        seq_d = START;
    else if (!en)   seq_d = seq_q;
    else if (legal) seq_d = shifted;
    else            seq_d = START;
  end

  always_ff @(posedge clk) begin
    seq_q <= seq_d;
  end
endmodule

// File: rtl/tgg_decode.sv
module tgg_decode
  import tgg_pkg::*;
#(
  parameter int W   = RING_W,
  parameter int NPH = NUM_PH
) (
  input  logic [W-1:0]   seq,
  output logic [NPH-1:0] phase
);
  genvar k;
  generate
    for (k = 0; k < NPH; k++) begin : g_phase
      assign phase[k] = seq[PH_SEL[k*SEL_W +: SEL_W]] ^ PH_INV[k];
    end
  endgenerate
endmodule

// File: rtl/tgg_outreg.sv
module tgg_outreg #(
  parameter int NPH = 3
) (
  input  logic           clk,
  input  logic [NPH-1:0] phase_d,
  input  logic           mark_d,
  output logic [NPH-1:0] phase_q,
  output logic           mark_q
);
  always_ff @(posedge clk) begin
    phase_q <= phase_d;
    mark_q  <= mark_d;
  end
endmodule

// File: rtl/tri_gate_gen.sv
module tri_gate_gen
  import tgg_pkg::*;
#(
  parameter int W   = RING_W,
  parameter int NPH = NUM_PH
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           en,
  output logic [NPH-1:0] phase_o,
  output logic           cyc_mark
);
  localparam logic [W-1:0] START = {{(W-1){1'b0}}, 1'b1};

  logic [W-1:0]   seq_d;
  logic [W-1:0]   seq_q;
  logic [NPH-1:0] phase_d;
  logic           mark_d;

  tgg_ring #(.W(W)) u_ring (
    .clk   (clk),
    .rst   (rst),
    .en    (en),
    .seq_d (seq_d),
    .seq_q (seq_q)
  );

  tgg_decode #(.W(W), .NPH(NPH)) u_dec (
    .seq   (seq_d),
    .phase (phase_d)
  );

  assign mark_d = !rst && en && (seq_d == START);

  tgg_outreg #(.NPH(NPH)) u_oreg (
    .clk     (clk),
    .phase_d (phase_d),
    .mark_d  (mark_d),
    .phase_q (phase_o),
    .mark_q  (cyc_mark)
  );
endmodule

// File: rtl/tgg_checker.sv
module tgg_checker (
  input logic       clk,
  input logic       rst,
  input logic       en,
  input logic [2:0] phase_o,
  input logic       cyc_mark
);
  a_r1_reset_state: assert property (@(posedge clk)
    $past(rst) |-> (phase_o == 3'b101 && !cyc_mark));

  a_r5_hold: assert property (@(posedge clk) disable iff (rst)
    (!en && !rst) |=> $stable(phase_o));

  a_r6_mark_single: assert property (@(posedge clk) disable iff (rst)
    cyc_mark |=> !cyc_mark);

  a_r6_mark_at_start: assert property (@(posedge clk) disable iff (rst)
    cyc_mark |-> phase_o == 3'b101);

  a_r6_mark_low_when_idle: assert property (@(posedge clk) disable iff (rst)
    (!en && !rst) |=> !cyc_mark);

  a_r7_one_toggle: assert property (@(posedge clk) disable iff (rst)
    (en && !rst) |=> $countones(phase_o ^ $past(phase_o)) == 1);

  a_r2_legal_pattern: assert property (@(posedge clk) disable iff (rst)
    ($countones(phase_o) == 1 || $countones(phase_o) == 2));
endmodule

bind tri_gate_gen tgg_checker u_chk (
  .clk      (clk),
  .rst      (rst),
  .en       (en),
  .phase_o  (phase_o),
  .cyc_mark (cyc_mark)
);

// File: tb/tri_gate_gen_tb.sv
module tri_gate_gen_tb;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       en  = 1'b0;
  logic [2:0] phase_o;
  logic       cyc_mark;

  int n_chk = 0;
  int n_bad = 0;
  int idx   = 0;
  logic entered0 = 1'b0;

  always #2 clk = ~clk;

  tri_gate_gen u_dut (
    .clk      (clk),
    .rst      (rst),
    .en       (en),
    .phase_o  (phase_o),
    .cyc_mark (cyc_mark)
  );

  function automatic logic [2:0] pat(int s);
    logic [2:0] p;
    p[0] = (s <= 2);
    p[1] = (s >= 2 && s <= 4);
    p[2] = (s >= 4 || s == 0);
    return p;
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // one clock: drive at falling edge, update model, sample after rising edge
  task automatic step(logic r, logic e);
    @(negedge clk);
    rst = r;
    en  = e;
    @(posedge clk);
    #1;
    entered0 = 1'b0;
    if (r) idx = 0;
    else if (e) begin
      idx = (idx + 1) % 6;
      entered0 = (idx == 0);
    end
  endtask

  task automatic t_reset();
    step(1'b1, 1'b0);
    step(1'b1, 1'b1);
    chk("R1 phase", phase_o, 3'b101);
    chk("R1 mark", cyc_mark, 1'b0);
  endtask

  task automatic t_sequence();
    logic [2:0] prev;
    step(1'b1, 1'b0);
    prev = phase_o;
    for (int i = 0; i < 14; i++) begin
      step(1'b0, 1'b1);
      chk("R2 pattern", phase_o, pat(idx));
      chk("R6 mark", cyc_mark, entered0);
      chk("R7 one toggle", $countones(phase_o ^ prev), 1);
      prev = phase_o;
    end
  endtask

  task automatic t_period_duty();
    int hi [3];
    int rise [3];
    logic [2:0] prev;
    for (int k = 0; k < 3; k++) begin hi[k] = 0; rise[k] = 0; end
    step(1'b1, 1'b0);
    prev = phase_o;
    for (int i = 0; i < 12; i++) begin
      step(1'b0, 1'b1);
      for (int k = 0; k < 3; k++) begin
        if (phase_o[k]) hi[k]++;
        if (phase_o[k] && !prev[k]) rise[k]++;
      end
      prev = phase_o;
    end
    for (int k = 0; k < 3; k++) begin
      chk("R3 duty high count over 12", hi[k], 6);
      chk("R3 rises over 12 (period 6)", rise[k], 2);
    end
  endtask

  task automatic t_offset();
    int t_u;
    int t_v;
    int t_w;
    logic [2:0] prev;
    t_u = -1; t_v = -1; t_w = -1;
    step(1'b1, 1'b0);
    prev = phase_o;
    for (int i = 1; i <= 12; i++) begin
      step(1'b0, 1'b1);
      if (phase_o[0] && !prev[0] && t_u < 0) t_u = i;
      if (phase_o[1] && !prev[1] && t_u >= 0 && t_v < 0) t_v = i;
      if (phase_o[2] && !prev[2] && t_v >= 0 && t_w < 0) t_w = i;
      prev = phase_o;
    end
    chk("R4 U rise at edge 6", t_u, 6);
    chk("R4 V after U", t_v - t_u, 2);
    chk("R4 W after V", t_w - t_v, 2);
  endtask

  task automatic t_hold();
    logic [2:0] held;
    step(1'b1, 1'b0);
    step(1'b0, 1'b1);
    step(1'b0, 1'b1);
    held = phase_o;
    for (int i = 0; i < 5; i++) begin
      step(1'b0, 1'b0);
      chk("R5 frozen", phase_o, held);
      chk("R6 mark low while idle", cyc_mark, 1'b0);
    end
    step(1'b0, 1'b1);
    chk("R5 resume state 3", phase_o, pat(3));
    for (int i = 0; i < 3; i++) step(1'b0, 1'b1);
    chk("R6 mark after resume", cyc_mark, 1'b1);
    step(1'b0, 1'b0);
    chk("R6 mark cleared by idle", cyc_mark, 1'b0);
    chk("R5 frozen at state 0", phase_o, pat(0));
  endtask

  task automatic t_reset_mid();
    step(1'b1, 1'b0);
    for (int i = 0; i < 4; i++) step(1'b0, 1'b1);
    chk("R8 mid state 4", phase_o, pat(4));
    step(1'b1, 1'b1);
    chk("R8 reset with en high", phase_o, 3'b101);
    chk("R8 mark low", cyc_mark, 1'b0);
    step(1'b0, 1'b1);
    chk("R8 restart state 1", phase_o, pat(1));
    step(1'b1, 1'b0);
    chk("R8 reset with en low", phase_o, 3'b101);
  endtask

  initial begin : watchdog
    #400000;
    n_chk++;
    n_bad++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    t_reset();
    t_sequence();
    t_period_duty();
    t_offset();
    t_hold();
    t_reset_mid();
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule